// File: doc/BRIEF.md
# Global Shutter Pulse Sequencer

This block drives the per-frame storage and exposure pulses of a global-shutter pixel array. A frame-start request starts one sequence. First the memory-boost line drops. While it is low, the in-pixel memory is first precharged to its reference level and then loaded with the photodiode value by the sample pulse. Then the boost line returns high. At that point the readout logic is told it may begin, and the photodiode reset pulse starts. A second, optional reset pulse can follow to give dual-slope exposure.

Every width and gap is a clock-cycle count taken from the configuration inputs. The block samples these counts once, on the cycle a frame is accepted. Any count below its hardware minimum is raised to that minimum. The time the boost line is low is the frame overhead, and it is stretched when needed to reach its own floor. A longer reset pulse means a shorter exposure, because exposure runs from the fall of reset to the rise of the next sample pulse. A guard period after the reset phase keeps that exposure above its minimum.

Top module: `gs_pulse_seq`

## Requirements
- R1: While reset is held and after it is released with no frame started, boost_o is 1, busy_o is 0 and every other output is 0.
- R2: A frame start sampled high in the idle state drives boost_o low from the next cycle. Boost stays low for the lead count. Precharge is then high for its count, then a gap, then sample high for its count, then a tail, and then boost_o returns to 1.
- R3: Precharge and sample are high only while boost_o is low, and they are never high together.
- R4: A configured count below its minimum is used as that minimum. A count of zero therefore yields exactly the minimum width.
- R5: The boost-low time is at least MIN_LOW cycles. When the programmed phases add up to less, only the tail is lengthened, by exactly the shortfall.
- R6: In the first cycle with boost_o high again, ready_o is high for exactly one cycle. pdrst_o is high for the clamped reset count, starting in that same cycle.
- R7: The number of cycles from the fall of pdrst_o to the next rise of smpl_o is at least MIN_INTEG.
- R8: When dual-slope is enabled at frame start, dsrst_o goes high after pdrst_o falls and a clamped delay has passed, and it stays high for a clamped width. When dual-slope is disabled, dsrst_o stays 0 whatever the delay and width inputs hold.
- R9: Configuration inputs take effect only in the cycle a frame is accepted. Changing them during a frame leaves that frame's pulses unchanged.
- R10: busy_o equals the inverse of boost_o. A frame start is acted on only when the sequencer is idle. A frame start during the busy, reset, dual-slope or guard phases is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Request to begin a frame sequence |
| cfg_lead_i | input | CW | Cycles from boost fall to precharge rise |
| cfg_pre_i | input | CW | Precharge width |
| cfg_gap_i | input | CW | Cycles from precharge fall to sample rise |
| cfg_samp_i | input | CW | Sample width |
| cfg_tail_i | input | CW | Cycles from sample fall to boost rise |
| cfg_rst_i | input | CW | Photodiode reset width |
| cfg_ds_en_i | input | 1 | Dual-slope enable |
| cfg_ds_dly_i | input | CW | Cycles from reset fall to dual-slope pulse |
| cfg_ds_w_i | input | CW | Dual-slope pulse width |
| boost_o | output | 1 | Memory-boost envelope, low during storage |
| pchg_o | output | 1 | Memory precharge pulse |
| smpl_o | output | 1 | Sample pulse |
| pdrst_o | output | 1 | Photodiode reset pulse |
| dsrst_o | output | 1 | Dual-slope reset pulse |
| busy_o | output | 1 | High while boost is low |
| ready_o | output | 1 | One-cycle readout-may-start strobe |

## Verification
The properties assume that every MIN_* parameter is at least one. They also assume that MIN_LOW, MIN_INTEG and the configured counts fit in CW bits, so that clamped values never wrap. The inputs themselves are not constrained: frame_start_i may be pulsed in any phase, and the configuration may change at any time. The stimulus uses small minimums and counts well below 2^CW. It deliberately pokes frame_start_i inside the storage window, the reset phase and the guard phase, and it rewrites the configuration mid-frame, so that the assumed ranges hold while every phase still sees these disturbances.

// File: rtl/gsps_pkg.sv
package gsps_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_PRE, PH_GAP, PH_SAMP, PH_TAIL,
    PH_RST, PH_DSW, PH_DSP, PH_GUARD
  } phase_e;

  // Slots of the duration vector
  localparam int unsigned NDUR    = 8;
  localparam int unsigned IX_LEAD = 0;
  localparam int unsigned IX_PRE  = 1;
  localparam int unsigned IX_GAP  = 2;
  localparam int unsigned IX_SAMP = 3;
  localparam int unsigned IX_TAIL = 4;
  localparam int unsigned IX_RST  = 5;
  localparam int unsigned IX_DSD  = 6;
  localparam int unsigned IX_DSW  = 7;

  // Raise a count to its floor
  function automatic int unsigned floor_to(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // Tail that makes head + tail reach min_low
  function automatic int unsigned fill_tail(int unsigned head, int unsigned tail,
                                            int unsigned min_low);
    return ((head + tail) < min_low) ? (min_low - head) : tail;
  endfunction

  // Cycles to hold after reset so that exposure cannot undercut integ
  function automatic int unsigned guard_len(int unsigned integ, int unsigned head_min);
    return (integ > (head_min + 1)) ? (integ - head_min - 1) : 0;
  endfunction

endpackage

// File: rtl/gsps_cfg_snap.sv
module gsps_cfg_snap
  import gsps_pkg::*;
#(
  parameter int unsigned             CW      = 16,
  parameter logic [NDUR-1:0][31:0]   MIN_TAB = '0,
  parameter int unsigned             MIN_LOW = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      capture_i,
  input  logic [NDUR-1:0][CW-1:0]   raw_i,
  input  logic                      ds_en_i,
  output logic [NDUR-1:0][CW-1:0]   dur_o,
  output logic                      ds_en_o
);

  logic [NDUR-1:0][CW-1:0] live;
  logic [NDUR-1:0][CW-1:0] held;
  logic                    ds_en_q;
  int unsigned             head_sum;

  assign head_sum = floor_to(32'(raw_i[IX_LEAD]), MIN_TAB[IX_LEAD])
                  + floor_to(32'(raw_i[IX_PRE]),  MIN_TAB[IX_PRE])
                  + floor_to(32'(raw_i[IX_GAP]),  MIN_TAB[IX_GAP])
                  + floor_to(32'(raw_i[IX_SAMP]), MIN_TAB[IX_SAMP]);

  for (genvar k = 0; k < NDUR; k++) begin : g_clamp
    if (k == IX_TAIL) begin : g_tail
      assign live[k] = CW'(fill_tail(head_sum,
                                     floor_to(32'(raw_i[k]), MIN_TAB[k]),
                                     MIN_LOW));
    end else begin : g_plain
      assign live[k] = CW'(floor_to(32'(raw_i[k]), MIN_TAB[k]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held    <= '0;
      ds_en_q <= 1'b0;
    end else if (capture_i) begin
      held    <= live;
      ds_en_q <= ds_en_i;
    end
  end

  // In the accept cycle the live values feed the first phase load
  assign dur_o   = capture_i ? live    : held;
  assign ds_en_o = capture_i ? ds_en_i : ds_en_q;

endmodule

// File: rtl/gsps_timer.sv
module gsps_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);

  logic [CW-1:0] cnt;

  // A phase of len cycles: load len-1, end when zero is reached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done_o = (cnt == '0);

endmodule

// File: rtl/gsps_phase_fsm.sv
module gsps_phase_fsm
  import gsps_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned GUARD_LEN = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic                    done_i,
  input  logic [NDUR-1:0][CW-1:0] dur_i,
  input  logic                    ds_en_i,
  output phase_e                  phase_o,
  output logic                    accept_o,
  output logic                    load_o,
  output logic [CW-1:0]           len_o,
  output logic                    ready_o
);

  localparam logic [CW-1:0] GUARD_CNT = CW'(GUARD_LEN);
  localparam bit            HAS_GUARD = (GUARD_LEN > 0);

  phase_e ph_q, ph_d;
  logic   ready_q;

  always_comb begin
    ph_d     = ph_q;
    load_o   = 1'b0;
    len_o    = '0;
    accept_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (frame_start_i) begin
        ph_d = PH_LEAD; load_o = 1'b1; len_o = dur_i[IX_LEAD]; accept_o = 1'b1;
      end
      PH_LEAD: if (done_i) begin
        ph_d = PH_PRE;  load_o = 1'b1; len_o = dur_i[IX_PRE];
      end
      PH_PRE: if (done_i) begin
        ph_d = PH_GAP;  load_o = 1'b1; len_o = dur_i[IX_GAP];
      end
      PH_GAP: if (done_i) begin
        ph_d = PH_SAMP; load_o = 1'b1; len_o = dur_i[IX_SAMP];
      end
      PH_SAMP: if (done_i) begin
        ph_d = PH_TAIL; load_o = 1'b1; len_o = dur_i[IX_TAIL];
      end
      PH_TAIL: if (done_i) begin
        ph_d = PH_RST;  load_o = 1'b1; len_o = dur_i[IX_RST];
      end
      PH_RST: if (done_i) begin
        if (ds_en_i) begin
          ph_d = PH_DSW; load_o = 1'b1; len_o = dur_i[IX_DSD];
        end else if (HAS_GUARD) begin
          ph_d = PH_GUARD; load_o = 1'b1; len_o = GUARD_CNT;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_DSW: if (done_i) begin
        ph_d = PH_DSP;  load_o = 1'b1; len_o = dur_i[IX_DSW];
      end
      PH_DSP: if (done_i) begin
        if (HAS_GUARD) begin
          ph_d = PH_GUARD; load_o = 1'b1; len_o = GUARD_CNT;
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_GUARD: if (done_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      ready_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      ready_q <= (ph_q == PH_TAIL) && done_i;
    end
  end

  assign phase_o = ph_q;
  assign ready_o = ready_q;

endmodule

// File: rtl/gs_pulse_seq.sv
module gs_pulse_seq
  import gsps_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned MIN_LEAD  = 26,
  parameter int unsigned MIN_PRE   = 63,
  parameter int unsigned MIN_GAP   = 51,
  parameter int unsigned MIN_SAMP  = 488,
  parameter int unsigned MIN_TAIL  = 1,
  parameter int unsigned MIN_LOW   = 626,
  parameter int unsigned MIN_RST   = 4,
  parameter int unsigned MIN_INTEG = 251,
  parameter int unsigned MIN_DSD   = 1,
  parameter int unsigned MIN_DSW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic [CW-1:0] cfg_lead_i,
  input  logic [CW-1:0] cfg_pre_i,
  input  logic [CW-1:0] cfg_gap_i,
  input  logic [CW-1:0] cfg_samp_i,
  input  logic [CW-1:0] cfg_tail_i,
  input  logic [CW-1:0] cfg_rst_i,
  input  logic          cfg_ds_en_i,
  input  logic [CW-1:0] cfg_ds_dly_i,
  input  logic [CW-1:0] cfg_ds_w_i,
  output logic          boost_o,
  output logic          pchg_o,
  output logic          smpl_o,
  output logic          pdrst_o,
  output logic          dsrst_o,
  output logic          busy_o,
  output logic          ready_o
);

  localparam logic [NDUR-1:0][31:0] MIN_TAB = {
    32'(MIN_DSW), 32'(MIN_DSD), 32'(MIN_RST), 32'(MIN_TAIL),
    32'(MIN_SAMP), 32'(MIN_GAP), 32'(MIN_PRE), 32'(MIN_LEAD)};
  localparam int unsigned HEAD_MIN  = MIN_LEAD + MIN_PRE + MIN_GAP;
  localparam int unsigned GUARD_LEN = guard_len(MIN_INTEG, HEAD_MIN);

  logic [NDUR-1:0][CW-1:0] raw;
  logic [NDUR-1:0][CW-1:0] dur;
  logic                    ds_en_eff;
  logic                    frame_accept;
  logic                    tmr_load;
  logic [CW-1:0]           tmr_len;
  logic                    tmr_done;
  logic                    store_win;
  phase_e                  ph;

  assign raw[IX_LEAD] = cfg_lead_i;
  assign raw[IX_PRE]  = cfg_pre_i;
  assign raw[IX_GAP]  = cfg_gap_i;
  assign raw[IX_SAMP] = cfg_samp_i;
  assign raw[IX_TAIL] = cfg_tail_i;
  assign raw[IX_RST]  = cfg_rst_i;
  assign raw[IX_DSD]  = cfg_ds_dly_i;
  assign raw[IX_DSW]  = cfg_ds_w_i;

  gsps_cfg_snap #(.CW(CW), .MIN_TAB(MIN_TAB), .MIN_LOW(MIN_LOW)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (frame_accept),
    .raw_i     (raw),
    .ds_en_i   (cfg_ds_en_i),
    .dur_o     (dur),
    .ds_en_o   (ds_en_eff)
  );

  gsps_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  gsps_phase_fsm #(.CW(CW), .GUARD_LEN(GUARD_LEN)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .done_i        (tmr_done),
    .dur_i         (dur),
    .ds_en_i       (ds_en_eff),
    .phase_o       (ph),
    .accept_o      (frame_accept),
    .load_o        (tmr_load),
    .len_o         (tmr_len),
    .ready_o       (ready_o)
  );

  // Storage window: every phase where the boost line is held low
  assign store_win = (ph == PH_LEAD) || (ph == PH_PRE) || (ph == PH_GAP) ||
                     (ph == PH_SAMP) || (ph == PH_TAIL);

  assign boost_o = !store_win;
  assign busy_o  = store_win;
  assign pchg_o  = (ph == PH_PRE);
  assign smpl_o  = (ph == PH_SAMP);
  assign pdrst_o = (ph == PH_RST);
  assign dsrst_o = (ph == PH_DSP);

endmodule

// File: rtl/gsps_checker.sv
module gsps_checker #(
  parameter int unsigned MIN_LEAD  = 1,
  parameter int unsigned MIN_PRE   = 1,
  parameter int unsigned MIN_GAP   = 1,
  parameter int unsigned MIN_SAMP  = 1,
  parameter int unsigned MIN_LOW   = 1,
  parameter int unsigned MIN_INTEG = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_accept,
  input logic boost_o,
  input logic pchg_o,
  input logic smpl_o,
  input logic pdrst_o,
  input logic dsrst_o,
  input logic busy_o,
  input logic ready_o
);

  logic [31:0] low_cnt, pre_cnt, gap_cnt, smp_cnt, exp_cnt;
  logic        seen_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt  <= '0;
      pre_cnt  <= '0;
      gap_cnt  <= '0;
      smp_cnt  <= '0;
      exp_cnt  <= '0;
      seen_rst <= 1'b0;
    end else begin
      low_cnt  <= boost_o ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 1);
      pre_cnt  <= pchg_o ? ((pre_cnt == '1) ? pre_cnt : pre_cnt + 1) : '0;
      gap_cnt  <= pchg_o ? '0 : ((gap_cnt == '1) ? gap_cnt : gap_cnt + 1);
      smp_cnt  <= smpl_o ? ((smp_cnt == '1) ? smp_cnt : smp_cnt + 1) : '0;
      exp_cnt  <= pdrst_o ? '0 : ((exp_cnt == '1) ? exp_cnt : exp_cnt + 1);
      seen_rst <= seen_rst | pdrst_o;
    end
  end

  a_r3_store_inside_boost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pchg_o || smpl_o) |-> !boost_o);
  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pchg_o && smpl_o));
  a_r4_lead_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pchg_o) |-> low_cnt >= MIN_LEAD);
  a_r4_pre_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pchg_o) |-> pre_cnt >= MIN_PRE);
  a_r4_gap_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smpl_o) |-> gap_cnt >= MIN_GAP);
  a_r4_samp_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(smpl_o) |-> smp_cnt >= MIN_SAMP);
  a_r5_low_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_o) |-> low_cnt >= MIN_LOW);
  a_r6_ready_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_o) |-> (ready_o && pdrst_o));
  a_r6_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r7_exposure_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(smpl_o) && seen_rst) |-> exp_cnt >= MIN_INTEG);
  a_r8_ds_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsrst_o |-> (boost_o && !pdrst_o));
  a_r10_busy_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != boost_o);
  a_r10_busy_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_accept));
  a_r10_accept_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_accept |-> (boost_o && !pdrst_o && !dsrst_o));

endmodule

bind gs_pulse_seq gsps_checker #(
  .MIN_LEAD (MIN_LEAD),
  .MIN_PRE  (MIN_PRE),
  .MIN_GAP  (MIN_GAP),
  .MIN_SAMP (MIN_SAMP),
  .MIN_LOW  (MIN_LOW),
  .MIN_INTEG(MIN_INTEG)
) u_gsps_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_accept (frame_accept),
  .boost_o      (boost_o),
  .pchg_o       (pchg_o),
  .smpl_o       (smpl_o),
  .pdrst_o      (pdrst_o),
  .dsrst_o      (dsrst_o),
  .busy_o       (busy_o),
  .ready_o      (ready_o)
);

// File: tb/test_gs_pulse_seq.sv
`timescale 1ns/1ps
module test_gs_pulse_seq;

  localparam int CW = 16;
  localparam int ML = 2, MP = 3, MG = 2, MS = 4, MT = 1, MLOW = 20;
  localparam int MR = 3, MI = 12, MDD = 1, MDW = 2;
  localparam int GRD = (MI > ML + MP + MG + 1) ? MI - (ML + MP + MG + 1) : 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic [CW-1:0] c_lead = '0, c_pre = '0, c_gap = '0, c_samp = '0, c_tail = '0;
  logic [CW-1:0] c_rst = '0, c_dsd = '0, c_dsw = '0;
  logic c_dsen = 1'b0;
  logic boost, pchg, smpl, pdrst, dsrst, busy, ready;

  always #4 clk = ~clk;

  gs_pulse_seq #(
    .CW(CW), .MIN_LEAD(ML), .MIN_PRE(MP), .MIN_GAP(MG), .MIN_SAMP(MS),
    .MIN_TAIL(MT), .MIN_LOW(MLOW), .MIN_RST(MR), .MIN_INTEG(MI),
    .MIN_DSD(MDD), .MIN_DSW(MDW)
  ) i_gs_pulse_seq (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_lead_i(c_lead), .cfg_pre_i(c_pre), .cfg_gap_i(c_gap),
    .cfg_samp_i(c_samp), .cfg_tail_i(c_tail), .cfg_rst_i(c_rst),
    .cfg_ds_en_i(c_dsen), .cfg_ds_dly_i(c_dsd), .cfg_ds_w_i(c_dsw),
    .boost_o(boost), .pchg_o(pchg), .smpl_o(smpl), .pdrst_o(pdrst),
    .dsrst_o(dsrst), .busy_o(busy), .ready_o(ready)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Scoreboard: expected runs of the output vector
  // bits: boost pchg smpl pdrst dsrst busy ready
  logic [6:0] qv[$];
  int         ql[$];
  bit         qm[$];
  string      qr[$];
  logic [6:0] cur_v = 7'b1000000;
  int         cur_len = 0;

  function automatic int lift(int v, int lo);
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic push(logic [6:0] v, int len, bit at_least, string req);
    qv.push_back(v); ql.push_back(len); qm.push_back(at_least); qr.push_back(req);
  endtask

  task automatic close_run();
    logic [6:0] ev; int el; bit em; string er;
    n_chk++;
    if (qv.size() == 0) begin
      n_bad++;
      $display("FAIL R10 unexpected run: actual %b x%0d expected none", cur_v, cur_len);
      return;
    end
    ev = qv.pop_front(); el = ql.pop_front(); em = qm.pop_front(); er = qr.pop_front();
    if (cur_v !== ev || (em ? (cur_len < el) : (cur_len != el))) begin
      n_bad++;
      $display("FAIL %s: actual %b x%0d expected %b x%0d%s", er, cur_v, cur_len,
               ev, el, em ? "+" : "");
    end
  endtask

  // Monitor samples away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if ({boost, pchg, smpl, pdrst, dsrst, busy, ready} === cur_v) cur_len++;
      else begin
        close_run();
        cur_v = {boost, pchg, smpl, pdrst, dsrst, busy, ready};
        cur_len = 1;
      end
    end
  end

  // Driver: called at a negedge; returns at the negedge when the frame is done
  task automatic run_frame(int lead, int pre, int gap, int samp, int tail, int rstw,
                           bit dsen, int dsd, int dsw, int poke, int chg, string tag);
    int e_lead, e_pre, e_gap, e_samp, e_tail, e_rst, e_dsd, e_dsw, low, tot, pk;
    e_lead = lift(lead, ML); e_pre = lift(pre, MP); e_gap = lift(gap, MG);
    e_samp = lift(samp, MS); e_tail = lift(tail, MT); e_rst = lift(rstw, MR);
    e_dsd = lift(dsd, MDD); e_dsw = lift(dsw, MDW);
    low = e_lead + e_pre + e_gap + e_samp + e_tail;
    if (low < MLOW) begin
      e_tail = e_tail + (MLOW - low);
      low = MLOW;
    end
    tot = low + e_rst + (dsen ? e_dsd + e_dsw : 0) + GRD;
    pk = (poke == -2) ? tot - 2 : poke;
    push(7'b0000010, e_lead, 0, {"R2 lead/", tag});
    push(7'b0100010, e_pre,  0, {"R4 precharge/", tag});
    push(7'b0000010, e_gap,  0, {"R3 gap/", tag});
    push(7'b0010010, e_samp, 0, {"R3 sample/", tag});
    push(7'b0000010, e_tail, 0, {"R5 tail/", tag});
    push(7'b1001001, 1,      0, {"R6 ready/", tag});
    push(7'b1001000, e_rst - 1, 0, {"R6 reset/", tag});
    if (dsen) begin
      push(7'b1000000, e_dsd, 0, {"R8 ds delay/", tag});
      push(7'b1000100, e_dsw, 0, {"R8 ds pulse/", tag});
    end
    push(7'b1000000, GRD + 1, 1, {"R7 guard/", tag});
    c_lead = CW'(lead); c_pre = CW'(pre); c_gap = CW'(gap); c_samp = CW'(samp);
    c_tail = CW'(tail); c_rst = CW'(rstw); c_dsen = dsen;
    c_dsd = CW'(dsd); c_dsw = CW'(dsw);
    fs = 1'b1;
    @(posedge clk); @(negedge clk);
    fs = 1'b0;
    for (int i = 1; i < tot; i++) begin
      @(posedge clk); @(negedge clk);
      fs = (i == pk);
      if (i == chg) begin
        c_lead = 40; c_pre = 40; c_gap = 40; c_samp = 40; c_tail = 40;
        c_rst = 40; c_dsen = ~c_dsen; c_dsd = 40; c_dsw = 40;
      end
    end
    @(posedge clk); @(negedge clk);
    fs = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: values during reset
    @(negedge clk); @(negedge clk);
    n_chk++;
    if ({boost, pchg, smpl, pdrst, dsrst, busy, ready} !== 7'b1000000) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b expected %b",
               {boost, pchg, smpl, pdrst, dsrst, busy, ready}, 7'b1000000);
    end
    push(7'b1000000, 1, 1, "R1 idle");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: plain counts above the floors
    run_frame(3, 4, 3, 6, 5, 6, 0, 0, 0, -1, -1, "R2");
    // R4 and R5: all-zero counts clamp and stretch the tail
    run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0, -1, -1, "R4");
    // R9: dual-slope with a mid-frame config rewrite and a start poke while busy
    run_frame(4, 5, 2, 5, 2, 5, 1, 3, 4, 3, 6, "R9");
    // R10: start poked during the reset phase; ds counts clamped
    run_frame(2, 3, 2, 4, 9, 4, 1, 0, 0, 21, -1, "R10");
    // R8: ds disabled with nonzero ds counts; start poked in the guard
    run_frame(6, 3, 4, 8, 1, 7, 0, 5, 5, -2, -1, "R8");
    repeat (GRD + 6) @(negedge clk);
    finished = 1;
    close_run();
    n_chk++;
    if (qv.size() != 0) begin
      n_bad++;
      $display("FAIL R2 leftover runs: actual %0d expected 0", qv.size());
    end
    summary();
    $finish;
  end

endmodule